// File: doc/BRIEF.md
# Encoded SPI Clock Divider

This block derives the serial clock of an SPI flash port from the bus clock. The divisor does not arrive as a binary number. It comes from a chip-select control word in which a 4-bit code selects a divisor from 1 to 16 through an interleaved mapping. A second field extends that range, and which field does so is fixed by a build-time variant. In the basic variant, one control bit multiplies the divisor by four. In the extended variant, a 4-bit base field adds sixteen bus cycles per step.

The block drives `sck` together with two single-cycle strobes for the shifter. One marks the first bus cycle of each high phase and the other marks the first bus cycle of each low phase. `sck` stays low while `enable` is low. The divisor is taken from the control word only while chip select is deasserted, so a transfer in progress always runs at one rate.

A separate combinational chooser is included. It takes the bus clock frequency and a requested maximum serial frequency, and returns the control-word field for the smallest divisor whose output rate does not exceed the request. The returned field has the same bit positions that the divider decodes.

Top module: `spi_sck_divider`

## Requirements
- R1: The divider code sits in control bits [11:8]. An odd divisor 2k+1 (k = 0..7) is selected by code 15-k, and an even divisor 2k+2 is selected by code 7-k. Code 15 therefore gives divisor 1 and code 0 gives divisor 16.
- R2: In the basic variant, setting control bit 13 makes the effective divisor four times the coded divisor. Bits [27:24] have no effect.
- R3: In the extended variant, bits [27:24] hold a base j and the effective divisor is the coded divisor plus 16·j. Bit 13 has no effect. The combination j = 0 with code 15 is not allowed, and the divider runs at divisor 2 in that case.
- R4: For an effective divisor N > 1, `sck` is high for ceil(N/2) bus cycles and low for floor(N/2) bus cycles. The first high phase begins at the first rising edge that samples `enable` high. `sck_rise` is high only in the first cycle of each high phase, and `sck_fall` only in the first cycle of each low phase.
- R5: For N = 1, `sck` is the bus clock gated by the running state, and both strobes are high in every running cycle.
- R6: After reset, and from the first rising edge that samples `enable` low, `sck` is low and `sck_rise` is low.
- R7: The divisor is captured from the control word on rising edges where `cs_active` is low. While `cs_active` is high, changes to the control word leave the running waveform unchanged.
- R8: In the basic variant, the chooser returns the smallest divisor whose rate floor(src/d) does not exceed the request. It first tries d = 1..16, returning code<<8. It then tries d = 4·(1..16), returning code<<8 with bit 13 set. If no divisor fits, it returns 0 with `sel_fits` low.
- R9: In the extended variant, the chooser searches divisors 2 to 240 written as coded divisor + 16·j with j in 0..14, and returns code<<8 | j<<24. If no divisor fits, it returns 0x0000_0400 with `sel_fits` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the serial clock when high |
| cs_active | input | 1 | Chip select asserted; freezes the captured divisor |
| ctrl_word | input | 32 | Chip-select control word holding the divider fields |
| req_src_hz | input | 32 | Bus clock frequency for the chooser |
| req_max_hz | input | 32 | Requested maximum serial frequency |
| sck | output | 1 | Serial clock |
| sck_rise | output | 1 | First cycle of a high phase |
| sck_fall | output | 1 | First cycle of a low phase |
| sel_field | output | 32 | Chosen control-word divider field |
| sel_fits | output | 1 | High when some divisor meets the request |

## Verification
The bench checks divisor 1: a design that treated it like any other divisor would hold `sck` high instead of following the bus clock. It checks odd divisors, where a wrong half-period would swap the long and short phases. It also checks the forbidden extended code, which a careless decoder would run at divisor 1 and so double the clock. Each variant is given the field it must ignore, which catches a design that decodes both extensions at once. The bench changes the control word mid-transfer, which a design lacking the capture gate would follow. For the chooser, it uses a request that lands on an exact floor-division boundary, where a ceiling-based compare picks the wrong divisor, and requests too low for any divisor, which must yield the variant's fallback field.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
    localparam int CODE_W = 4;
    localparam int CODES  = 1 << CODE_W;
    localparam int HALF   = CODES / 2;

    // Interleaved code -> divisor: upper half encodes odd divisors, lower half even.
    function automatic int code_to_div(input logic [CODE_W-1:0] c);
        int cv;
        cv = int'(c);
        if (cv >= HALF) return 2 * (CODES - 1 - cv) + 1;
        else            return 2 * (HALF - 1 - cv) + 2;
    endfunction

    // Inverse of code_to_div for divisors 1..CODES.
    function automatic logic [CODE_W-1:0] div_to_code(input int d);
        if ((d % 2) == 1) return CODE_W'(CODES - 1 - (d - 1) / 2);
        else              return CODE_W'(HALF - 1 - (d - 2) / 2);
    endfunction
endpackage

// File: rtl/sckdiv_field_decode.sv
module sckdiv_field_decode #(
    parameter int CTRL_W   = 32,
    parameter int CODE_LSB = 8,
    parameter int PRE_BIT  = 13,
    parameter int BASE_LSB = 24,
    parameter int BASE_W   = 4,
    parameter bit EXTENDED = 1'b0,
    parameter int DIV_W    = 9
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [DIV_W-1:0]  div
);
    import sckdiv_pkg::*;

    logic [CODE_W-1:0] code;
    logic [BASE_W-1:0] base;
    logic [DIV_W-1:0]  coded;
    logic              unused_ctrl;

    assign code        = ctrl_word[CODE_LSB +: CODE_W];
    assign base        = ctrl_word[BASE_LSB +: BASE_W];
    assign coded       = DIV_W'(code_to_div(code));
    assign unused_ctrl = ^{ctrl_word, base};

    generate
        if (EXTENDED) begin : g_ext
            logic [DIV_W-1:0] sum;
            always_comb begin
                sum = coded + (DIV_W'(base) << CODE_W);
                // base 0 with the divide-by-one code is illegal: run at two
                if (sum == DIV_W'(1)) sum = DIV_W'(2);
                div = sum;
            end
        end else begin : g_basic
            always_comb begin
                div = ctrl_word[PRE_BIT] ? (coded << 2) : coded;
            end
        end
    endgenerate
endmodule

// File: rtl/sckdiv_phase_gen.sv
module sckdiv_phase_gen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             sck_rise,
    output logic             sck_fall
);
    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] pos;
        logic             sck;
        logic             rise;
        logic             fall;
    } phase_t;

    phase_t         st_d, st_q;
    logic [DIV_W:0] half_w;
    logic [DIV_W:0] nxt_w;
    logic           div_one;

    assign div_one = (div == DIV_W'(1));

    always_comb begin
        half_w  = ({1'b0, div} + 1'b1) >> 1;
        nxt_w   = {1'b0, st_q.pos} + 1'b1;
        st_d     = st_q;
        st_d.run = enable;
        if (!enable) begin
            st_d.pos  = '0;
            st_d.sck  = 1'b0;
            st_d.rise = 1'b0;
            st_d.fall = st_q.sck;
        end else begin
            if (!st_q.run || (nxt_w >= {1'b0, div})) st_d.pos = '0;
            else                                    st_d.pos = nxt_w[DIV_W-1:0];
            st_d.sck = ({1'b0, st_d.pos} < half_w);
            if (div_one) begin
                st_d.rise = 1'b1;
                st_d.fall = 1'b1;
            end else begin
                st_d.rise = st_d.sck & ~st_q.sck;
                st_d.fall = ~st_d.sck & st_q.sck;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Divisor one: the bus clock itself, gated by the running state.
    assign sck      = div_one ? (clk & st_q.sck) : st_q.sck;
    assign sck_rise = st_q.rise;
    assign sck_fall = st_q.fall;

    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!st_q.sck && !st_q.rise))
        else $error("sck not idle after enable dropped");

    p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((div != DIV_W'(1)) && ($past(div) != DIV_W'(1))) |-> $onehot0({st_q.rise, st_q.fall}))
        else $error("rise and fall strobes together");

    p_rise_in_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rise |-> st_q.sck)
        else $error("rise strobe outside high phase");
endmodule

// File: rtl/sckdiv_rate_pick.sv
module sckdiv_rate_pick #(
    parameter int CTRL_W   = 32,
    parameter int HZ_W     = 32,
    parameter int CODE_LSB = 8,
    parameter int PRE_BIT  = 13,
    parameter int BASE_LSB = 24,
    parameter int BASE_W   = 4,
    parameter bit EXTENDED = 1'b0
) (
    input  logic [HZ_W-1:0]   src_hz,
    input  logic [HZ_W-1:0]   max_hz,
    output logic [CTRL_W-1:0] field,
    output logic              fits
);
    import sckdiv_pkg::*;

    localparam int PW         = HZ_W + 10;
    localparam int BASE_STEPS = (1 << BASE_W) - 1;
    // extended fallback is the code for divisor CODES/2 with base zero
    localparam logic [CTRL_W-1:0] FALLBACK =
        EXTENDED ? (CTRL_W'(div_to_code(CODES / 2)) << CODE_LSB) : '0;

    logic [PW-1:0] src_w;
    logic [PW-1:0] lim_w;

    // floor(src/d) <= max  <=>  src < (max+1)*d
    assign src_w = PW'(src_hz);
    assign lim_w = PW'(max_hz) + PW'(1);

    generate
        if (EXTENDED) begin : g_ext
            always_comb begin
                fits  = 1'b0;
                field = FALLBACK;
                for (int j = 0; j < BASE_STEPS; j++) begin
                    for (int i = 0; i < CODES; i++) begin
                        if (!(i == 0 && j == 0) && !fits &&
                            (src_w < lim_w * PW'(i + 1 + CODES * j))) begin
                            fits  = 1'b1;
                            field = (CTRL_W'(div_to_code(i + 1)) << CODE_LSB) |
                                    (CTRL_W'(j) << BASE_LSB);
                        end
                    end
                end
            end
        end else begin : g_basic
            always_comb begin
                fits  = 1'b0;
                field = FALLBACK;
                for (int i = 0; i < CODES; i++) begin
                    if (!fits && (src_w < lim_w * PW'(i + 1))) begin
                        fits  = 1'b1;
                        field = CTRL_W'(div_to_code(i + 1)) << CODE_LSB;
                    end
                end
                for (int i = 0; i < CODES; i++) begin
                    if (!fits && (src_w < lim_w * PW'(4 * (i + 1)))) begin
                        fits  = 1'b1;
                        field = (CTRL_W'(div_to_code(i + 1)) << CODE_LSB) |
                                (CTRL_W'(1) << PRE_BIT);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
    parameter int CTRL_W   = 32,
    parameter int HZ_W     = 32,
    parameter int CODE_LSB = 8,
    parameter int PRE_BIT  = 13,
    parameter int BASE_LSB = 24,
    parameter int BASE_W   = 4,
    parameter bit EXTENDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cs_active,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [HZ_W-1:0]   req_src_hz,
    input  logic [HZ_W-1:0]   req_max_hz,
    output logic              sck,
    output logic              sck_rise,
    output logic              sck_fall,
    output logic [CTRL_W-1:0] sel_field,
    output logic              sel_fits
);
    import sckdiv_pkg::*;

    localparam int MAX_DIV = EXTENDED ? CODES * (1 << BASE_W) : CODES * 4;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);
    localparam logic [DIV_W-1:0] RESET_DIV = DIV_W'(code_to_div(CODE_W'(0)));
    localparam logic [CTRL_W-1:0] FALLBACK =
        EXTENDED ? (CTRL_W'(div_to_code(CODES / 2)) << CODE_LSB) : '0;

    logic [DIV_W-1:0] dec_div;
    logic [DIV_W-1:0] div_d, div_q;

    sckdiv_field_decode #(
        .CTRL_W(CTRL_W), .CODE_LSB(CODE_LSB), .PRE_BIT(PRE_BIT),
        .BASE_LSB(BASE_LSB), .BASE_W(BASE_W), .EXTENDED(EXTENDED), .DIV_W(DIV_W)
    ) u_decode (
        .ctrl_word (ctrl_word),
        .div       (dec_div)
    );

    // capture the divisor only between transactions
    always_comb begin
        div_d = cs_active ? div_q : dec_div;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= RESET_DIV;
        else        div_q <= div_d;
    end

    sckdiv_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .div      (div_q),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    sckdiv_rate_pick #(
        .CTRL_W(CTRL_W), .HZ_W(HZ_W), .CODE_LSB(CODE_LSB), .PRE_BIT(PRE_BIT),
        .BASE_LSB(BASE_LSB), .BASE_W(BASE_W), .EXTENDED(EXTENDED)
    ) u_pick (
        .src_hz (req_src_hz),
        .max_hz (req_max_hz),
        .field  (sel_field),
        .fits   (sel_fits)
    );

    p_div_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active |=> $stable(div_q))
        else $error("divisor changed during a transaction");

    // R8 and R9: a failed search must report the variant's fallback field
    p_pick_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_fits |-> (sel_field == FALLBACK))
        else $error("fallback field wrong");
endmodule

// File: tb/spi_sck_divider_tb_top.sv
`timescale 1ns/1ps
module spi_sck_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cs_active = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [31:0] req_src_hz = 32'd200_000_000;
    logic [31:0] req_max_hz = 32'd50_000_000;
    logic        sck_b, rise_b, fall_b, fits_b;
    logic        sck_x, rise_x, fall_x, fits_x;
    logic [31:0] field_b, field_x;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi_sck_divider #(.EXTENDED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cs_active(cs_active),
        .ctrl_word(ctrl_word), .req_src_hz(req_src_hz), .req_max_hz(req_max_hz),
        .sck(sck_b), .sck_rise(rise_b), .sck_fall(fall_b),
        .sel_field(field_b), .sel_fits(fits_b));

    spi_sck_divider #(.EXTENDED(1'b1)) dut_ext_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cs_active(cs_active),
        .ctrl_word(ctrl_word), .req_src_hz(req_src_hz), .req_max_hz(req_max_hz),
        .sck(sck_x), .sck_rise(rise_x), .sck_fall(fall_x),
        .sel_field(field_x), .sel_fits(fits_x));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // divisor -> code, listed for divisors 1..16
    function automatic int code_of(input int d);
        case (d)
            1: return 15;  2: return 7;  3: return 14;  4: return 6;
            5: return 13;  6: return 5;  7: return 12;  8: return 4;
            9: return 11; 10: return 3; 11: return 10; 12: return 2;
           13: return 9;  14: return 1; 15: return 8;  default: return 0;
        endcase
    endfunction

    function automatic int div_of(input int c);
        for (int d = 1; d <= 16; d++) if (code_of(d) == c) return d;
        return 0;
    endfunction

    function automatic int exp_div(input logic [31:0] cw, input bit ext);
        int d;
        d = div_of(int'(cw[11:8]));
        if (ext) begin
            d = d + 16 * int'(cw[27:24]);
            if (d == 1) d = 2;
        end else if (cw[13]) d = 4 * d;
        return d;
    endfunction

    function automatic logic [2:0] exp_wave(input int n, input int m);
        int ph, h;
        if (n == 1) return 3'b111;
        ph = m % n;
        h  = (n + 1) / 2;
        return {ph < h, ph == 0, ph == h};
    endfunction

    function automatic logic [32:0] ref_pick(input longint src, input longint mx, input bit ext);
        if (ext) begin
            for (int j = 0; j < 15; j++)
                for (int i = 0; i < 16; i++) begin
                    if (i == 0 && j == 0) continue;
                    if (src / (i + 1 + 16 * j) <= mx)
                        return {1'b1, 32'(j) << 24 | 32'(code_of(i + 1)) << 8};
                end
            return {1'b0, 32'h0000_0400};
        end
        for (int i = 1; i <= 16; i++)
            if (src / i <= mx) return {1'b1, 32'(code_of(i)) << 8};
        for (int i = 1; i <= 16; i++)
            if (src / (4 * i) <= mx) return {1'b1, 32'h2000 | 32'(code_of(i)) << 8};
        return {1'b0, 32'h0};
    endfunction

    task automatic sample_both(input int nb, input int nx, input int m, input string req);
        logic [2:0] eb, ex;
        eb = exp_wave(nb, m);
        ex = exp_wave(nx, m);
        chk({sck_b, rise_b, fall_b} == eb, req, $sformatf("basic N=%0d m=%0d", nb, m),
            {sck_b, rise_b, fall_b}, eb);
        chk({sck_x, rise_x, fall_x} == ex, req, $sformatf("ext N=%0d m=%0d", nx, m),
            {sck_x, rise_x, fall_x}, ex);
    endtask

    task automatic idle_check(input string req);
        chk(!sck_b && !rise_b, req, "basic idle", {sck_b, rise_b}, 0);
        chk(!sck_x && !rise_x, req, "ext idle", {sck_x, rise_x}, 0);
    endtask

    // R1..R5 waveform for one control word, then R6 on disable
    task automatic t_wave(input logic [31:0] cw, input string req);
        int nb, nx, len;
        nb  = exp_div(cw, 1'b0);
        nx  = exp_div(cw, 1'b1);
        len = 2 * ((nb > nx) ? nb : nx) + 3;
        @(negedge clk);
        ctrl_word = cw; cs_active = 1'b0; enable = 1'b0;
        repeat (2) @(negedge clk);
        cs_active = 1'b1; enable = 1'b1;
        for (int m = 0; m < len; m++) begin
            @(posedge clk); #1;
            sample_both(nb, nx, m, req);
            if (nb == 1 || nx == 1) begin
                @(negedge clk); #1;
                if (nb == 1) chk(!sck_b, "R5", "basic gated low half", sck_b, 0);
                if (nx == 1) chk(!sck_x, "R5", "ext gated low half", sck_x, 0);
            end
        end
        @(negedge clk);
        enable = 1'b0; cs_active = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            idle_check("R6");
            @(negedge clk); #1;
            idle_check("R6");
        end
    endtask

    // R7: control word changes during an active chip select are ignored
    task automatic t_freeze;
        @(negedge clk);
        ctrl_word = 32'h0000_0700; cs_active = 1'b0; enable = 1'b0;
        repeat (2) @(negedge clk);
        cs_active = 1'b1; enable = 1'b1;
        for (int m = 0; m < 24; m++) begin
            @(posedge clk); #1;
            sample_both(2, 2, m, "R7");
            if (m == 4) begin
                @(negedge clk);
                ctrl_word = 32'h0000_0000;
            end
        end
        @(negedge clk);
        enable = 1'b0; cs_active = 1'b0;
        @(posedge clk); #1;
        idle_check("R6");
        t_wave(32'h0000_0000, "R7");
    endtask

    // R8 / R9 chooser
    task automatic t_pick(input longint src, input longint mx);
        logic [32:0] eb, ex;
        @(negedge clk);
        req_src_hz = 32'(src); req_max_hz = 32'(mx);
        #1;
        eb = ref_pick(src, mx, 1'b0);
        ex = ref_pick(src, mx, 1'b1);
        chk({fits_b, field_b} == eb, "R8", $sformatf("pick %0d/%0d", src, mx), {fits_b, field_b}, eb);
        chk({fits_x, field_x} == ex, "R9", $sformatf("pick %0d/%0d", src, mx), {fits_x, field_x}, ex);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        idle_check("R6");
        chk(!fall_b && !fall_x, "R6", "reset fall", {fall_b, fall_x}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        t_wave(32'h0000_0F00, "R5");   // basic N=1, ext forbidden -> 2 (R3)
        t_wave(32'h0000_0700, "R1");   // N=2
        t_wave(32'h0000_0E00, "R4");   // N=3 odd
        t_wave(32'h0000_0000, "R1");   // N=16
        t_wave(32'h0000_2E00, "R2");   // basic 12, ext ignores bit13 -> 3
        t_wave(32'h0300_0D00, "R3");   // basic 5, ext 53
        t_wave(32'h0F00_0000, "R3");   // basic 16, ext 256
        t_wave(32'h0100_0F00, "R3");   // basic 1, ext 17
        t_freeze();

        t_pick(200_000_000, 50_000_000);
        t_pick(200_000_000, 300_000_000);
        t_pick(200_000_000, 5_000_000);
        t_pick(200_000_000, 100_000);
        t_pick(100, 33);
        t_pick(100, 32);
        // explicit expectations, R8 and R9
        t_pick(200_000_000, 5_000_000);
        chk(field_b == 32'h0000_2300, "R8", "prescaled field", field_b, 32'h2300);
        chk(field_x == 32'h0200_0400, "R9", "based field", field_x, 32'h0200_0400);
        t_pick(200_000_000, 100_000);
        chk(!fits_x && field_x == 32'h400, "R9", "ext fallback", field_x, 32'h400);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule